// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the memory system and holds stores that have not yet reached memory, so the processor can keep executing instead of waiting on each store. The buffer has a small number of slots, and each slot covers one aligned block of several words. Each word in a slot has its own valid bit. A store whose block is already pending in a slot is folded into that slot. The effect is that a run of stores to neighbouring words leaves the block as a single wide memory write with a word mask, not as a string of single-word writes.

Slots drain strictly in the order they were allocated. The oldest slot is presented on the memory port with a valid/ready handshake. From the moment it is presented until memory takes it, that slot is frozen. When every slot is busy and a store cannot be merged, the processor is held off through a stall output. Reset is asynchronous and active low. The system is expected to deassert it synchronously to `clk`.

Top module: `wrmerge_buf`

## Requirements
- R1: While reset is asserted, and right after it is released, `mem_wr_valid` and `cpu_stall` are low and the buffer holds no entries.
- R2: A store is taken on a rising edge when `cpu_wr_valid` is high and `cpu_stall` is low. Its block is `cpu_wr_addr[ADDR_W-1:2]` and its word index is `cpu_wr_addr[1:0]`. If the store opens a new slot, the slot keeps its data in lane i (`mem_wr_data[32*i+31:32*i]`) for word i and sets only mask bit i. Lanes whose mask bit is clear read as zero.
- R3: A store whose block equals that of a valid slot which is not currently on the memory port is merged into that slot. Its word's mask bit is set and no new slot is used.
- R4: A store to a word that is already marked valid in its slot replaces that word's data and leaves the mask unchanged.
- R5: The slot being offered on the memory port accepts no merges. A store to its block opens a separate slot. While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_blk`, `mem_wr_mask` and `mem_wr_data` hold steady.
- R6: Slots are offered to memory oldest-allocated first.
- R7: When all DEPTH slots are in use and a store cannot merge, `cpu_stall` is high in that same cycle and the store is not taken. This holds whatever the value of `mem_wr_ready`. A store that merges is taken even when the buffer is full.
- R8: A slot leaves on an edge where `mem_wr_valid` and `mem_wr_ready` are both high. The next slot, if there is one, is offered from the following cycle; otherwise `mem_wr_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_valid | input | 1 | Processor store request |
| cpu_wr_addr | input | ADDR_W | Word address of the store |
| cpu_wr_data | input | DATA_W | Store data |
| cpu_stall | output | 1 | Store cannot be taken this cycle |
| mem_wr_valid | output | 1 | Oldest slot is offered to memory |
| mem_wr_ready | input | 1 | Memory takes the offered slot |
| mem_wr_blk | output | ADDR_W-2 | Block address of the offered slot |
| mem_wr_data | output | WORDS*DATA_W | Block data, word i in lane i |
| mem_wr_mask | output | WORDS | Word-valid mask of the offered slot |

## Verification
The hardest case to reach from the ports is a store arriving while the buffer is full. Two outcomes must be told apart: a store whose block matches a younger slot must be merged, and a store with a new block must be refused. The refusal has to hold even in the cycle where memory accepts the head. The stimulus table holds memory ready low while it fills every slot. It arranges for two slots to share a block, one of them the frozen head, and then offers both kinds of store with ready both low and high. A directed sequence then drains the slots one at a time, so that the merged masks, the overwritten words and the zeroed lanes can be read on the memory port.

// File: rtl/wrmerge_pkg.sv
package wrmerge_pkg;
  // Per-slot action selected by the queue control each cycle.
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_ALLOC = 2'd1,
    SLOT_MERGE = 2'd2
  } slot_op_e;
endpackage

// File: rtl/wrmerge_slot.sv
module wrmerge_slot
  import wrmerge_pkg::*;
#(
  parameter int BLK_W  = 30,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LANE_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  slot_op_e                op_i,
  input  logic                    clr_i,
  input  logic [BLK_W-1:0]        blk_i,
  input  logic [LANE_W-1:0]       lane_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    vld_o,
  output logic [BLK_W-1:0]        blk_o,
  output logic [WORDS-1:0]        mask_o,
  output logic [WORDS*DATA_W-1:0] data_o
);
  logic                    vld_q, vld_d;
  logic [WORDS-1:0]        mask_q, mask_d, lane_bit;
  logic [WORDS*DATA_W-1:0] data_q, data_d;
  logic [BLK_W-1:0]        blk_q;
  logic                    data_en, blk_en;

  assign lane_bit = {{(WORDS-1){1'b0}}, 1'b1} << lane_i;
  assign blk_en   = (op_i == SLOT_ALLOC);

  always_comb begin
    vld_d   = vld_q;
    mask_d  = mask_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (clr_i) begin
      vld_d  = 1'b0;
      mask_d = '0;
    end
    case (op_i)
      SLOT_ALLOC: begin
        vld_d   = 1'b1;
        mask_d  = lane_bit;
        data_d  = '0;
        data_d[lane_i*DATA_W +: DATA_W] = data_i;
        data_en = 1'b1;
      end
      SLOT_MERGE: begin
        mask_d  = mask_q | lane_bit;
        data_d[lane_i*DATA_W +: DATA_W] = data_i;
        data_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
    if (blk_en)  blk_q  <= blk_i;
  end

  assign vld_o  = vld_q;
  assign blk_o  = blk_q;
  assign mask_o = mask_q;
  assign data_o = data_q;

  // R3: merges only land in occupied slots and never drop a word bit
  assert_merge_on_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SLOT_MERGE) |-> vld_q);
  assert_mask_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SLOT_MERGE && !clr_i) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
  // R2: a new slot is only opened in a free slot, with exactly one word valid
  assert_alloc_on_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SLOT_ALLOC) |-> !vld_q);
  assert_alloc_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SLOT_ALLOC) |=> (vld_q && $onehot(mask_q)));
endmodule

// File: rtl/wrmerge_ctrl.sv
module wrmerge_ctrl
  import wrmerge_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int BLK_W = 30,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid_i,
  input  logic [BLK_W-1:0]            wr_blk_i,
  input  logic [DEPTH-1:0]            slot_vld_i,
  input  logic [DEPTH-1:0][BLK_W-1:0] slot_blk_i,
  input  logic                        mem_ready_i,
  output slot_op_e [DEPTH-1:0]        slot_op_o,
  output logic [DEPTH-1:0]            slot_clr_o,
  output logic [PTR_W-1:0]            head_o,
  output logic                        stall_o,
  output logic                        mem_valid_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [DEPTH-1:0] hit;
  logic             any_hit, full, alloc, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Block match against every occupied slot except the frozen head.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = slot_vld_i[i] && (slot_blk_i[i] == wr_blk_i) &&
               ((PTR_W'(i) != head_q) || (count_q == '0));
    end
  end

  assign any_hit     = |hit;
  assign full        = (count_q == CNT_W'(DEPTH));
  assign mem_valid_o = (count_q != '0);
  assign stall_o     = wr_valid_i && !any_hit && full;
  assign alloc       = wr_valid_i && !any_hit && !full;
  assign pop         = mem_valid_o && mem_ready_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc && (tail_q == PTR_W'(i)))   slot_op_o[i] = SLOT_ALLOC;
      else if (wr_valid_i && hit[i])        slot_op_o[i] = SLOT_MERGE;
      else                                  slot_op_o[i] = SLOT_IDLE;
      slot_clr_o[i] = pop && (head_q == PTR_W'(i));
    end
  end

  always_comb begin
    head_d  = pop   ? ptr_inc(head_q) : head_q;
    tail_d  = alloc ? ptr_inc(tail_q) : tail_q;
    count_d = count_q + CNT_W'(alloc) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head_o = head_q;

  // R7: occupancy never exceeds the slot count
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R3: at most one slot can be a merge target
  assert_hit_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R6: the head only moves when memory takes it
  assert_head_moves_on_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid_o && mem_ready_i) |=> $stable(head_q));
endmodule

// File: rtl/wrmerge_buf.sv
module wrmerge_buf
  import wrmerge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_wr_valid,
  input  logic [ADDR_W-1:0]         cpu_wr_addr,
  input  logic [DATA_W-1:0]         cpu_wr_data,
  output logic                      cpu_stall,
  output logic                      mem_wr_valid,
  input  logic                      mem_wr_ready,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_wr_blk,
  output logic [WORDS*DATA_W-1:0]   mem_wr_data,
  output logic [WORDS-1:0]          mem_wr_mask
);
  localparam int LANE_W = $clog2(WORDS);
  localparam int BLK_W  = ADDR_W - LANE_W;
  localparam int PTR_W  = $clog2(DEPTH);

  logic [BLK_W-1:0]                     wr_blk;
  logic [LANE_W-1:0]                    wr_lane;
  logic [DEPTH-1:0]                     slot_vld, slot_clr;
  logic [DEPTH-1:0][BLK_W-1:0]          slot_blk;
  logic [DEPTH-1:0][WORDS-1:0]          slot_mask;
  logic [DEPTH-1:0][WORDS*DATA_W-1:0]   slot_data;
  slot_op_e [DEPTH-1:0]                 slot_op;
  logic [PTR_W-1:0]                     head;

  assign wr_blk  = cpu_wr_addr[ADDR_W-1:LANE_W];
  assign wr_lane = cpu_wr_addr[LANE_W-1:0];

  wrmerge_ctrl #(.DEPTH(DEPTH), .BLK_W(BLK_W), .PTR_W(PTR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (cpu_wr_valid),
    .wr_blk_i    (wr_blk),
    .slot_vld_i  (slot_vld),
    .slot_blk_i  (slot_blk),
    .mem_ready_i (mem_wr_ready),
    .slot_op_o   (slot_op),
    .slot_clr_o  (slot_clr),
    .head_o      (head),
    .stall_o     (cpu_stall),
    .mem_valid_o (mem_wr_valid)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    wrmerge_slot #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS), .LANE_W(LANE_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .op_i   (slot_op[g]),
      .clr_i  (slot_clr[g]),
      .blk_i  (wr_blk),
      .lane_i (wr_lane),
      .data_i (cpu_wr_data),
      .vld_o  (slot_vld[g]),
      .blk_o  (slot_blk[g]),
      .mask_o (slot_mask[g]),
      .data_o (slot_data[g])
    );
  end

  assign mem_wr_blk  = slot_blk[head];
  assign mem_wr_mask = slot_mask[head];
  assign mem_wr_data = slot_data[head];

  // R5: an offered block stays frozen until memory takes it
  assert_mem_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_blk) && $stable(mem_wr_mask) && $stable(mem_wr_data)));
  // R7: a stall can only occur while entries are pending
  assert_stall_needs_entries_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> mem_wr_valid);
  // R2: an offered slot always carries at least one word
  assert_offer_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (mem_wr_mask != '0));
endmodule

// File: tb/wrmerge_buf_bench.sv
`timescale 1ns/1ps
module wrmerge_buf_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_wr_valid;
  logic [31:0]  cpu_wr_addr;
  logic [31:0]  cpu_wr_data;
  logic         cpu_stall;
  logic         mem_wr_valid;
  logic         mem_wr_ready;
  logic [29:0]  mem_wr_blk;
  logic [127:0] mem_wr_data;
  logic [3:0]   mem_wr_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wrmerge_buf u_wrmerge_buf (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr_valid(cpu_wr_valid), .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .cpu_stall(cpu_stall),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_blk(mem_wr_blk),
    .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask)
  );

  typedef struct packed {
    bit       wr;
    bit [7:0] addr;
    bit       rdy;
    bit       stall;
    bit       v;
    bit [7:0] blk;
    bit [3:0] mask;
  } row_t;

  // wr addr rdy | exp stall, valid, head block, head mask (after the edge)
  localparam row_t TBL [16] = '{
    '{1'b1, 8'h10, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h12, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h20, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h13, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h30, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h40, 1'b0, 1'b1, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h21, 1'b0, 1'b0, 1'b1, 8'h04, 4'h1},
    '{1'b1, 8'h40, 1'b1, 1'b1, 1'b1, 8'h04, 4'hE},
    '{1'b1, 8'h40, 1'b0, 1'b0, 1'b1, 8'h04, 4'hE},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h08, 4'h3},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0C, 4'h1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h10, 4'h1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0},
    '{1'b1, 8'h70, 1'b1, 1'b0, 1'b1, 8'h1C, 4'h1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 4'h0}
  };

  task automatic chk(input string req, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic wv, input logic [31:0] a, input logic [31:0] d,
                          input logic rdy);
    @(negedge clk);
    cpu_wr_valid = wv;
    cpu_wr_addr  = a;
    cpu_wr_data  = d;
    mem_wr_ready = rdy;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [29:0]  cap_blk;
    logic [127:0] cap_data;
    rst_n = 1'b0; cpu_wr_valid = 1'b0; cpu_wr_addr = '0; cpu_wr_data = '0; mem_wr_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "valid in reset", mem_wr_valid, 1'b0);
    chk("R1", "stall in reset", cpu_stall, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid after reset", mem_wr_valid, 1'b0);

    // Table walk: fill, full-buffer stall and merge, then ordered drain.
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      cpu_wr_valid = TBL[i].wr;
      cpu_wr_addr  = 32'(TBL[i].addr);
      cpu_wr_data  = 32'hC0DE_0000 | 32'(TBL[i].addr);
      mem_wr_ready = TBL[i].rdy;
      #1;
      chk("R7", $sformatf("row %0d stall", i), cpu_stall, TBL[i].stall);
      @(posedge clk);
      #1;
      chk("R8", $sformatf("row %0d valid", i), mem_wr_valid, TBL[i].v);
      if (TBL[i].v) begin
        chk("R6", $sformatf("row %0d block", i), mem_wr_blk, 30'(TBL[i].blk));
        chk("R3", $sformatf("row %0d mask", i), mem_wr_mask, TBL[i].mask);
      end
    end

    // Directed: head lock, overwrite and lane contents.
    @(negedge clk);
    cpu_wr_valid = 1'b0; mem_wr_ready = 1'b0; rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    wr_cycle(1'b1, 32'h50, 32'h5, 1'b0);
    chk("R2", "first block", mem_wr_blk, 30'h14);
    chk("R2", "lane0 data", mem_wr_data[31:0], 32'h5);
    chk("R2", "unused lanes zero", mem_wr_data[127:32], 96'h0);
    cap_blk = mem_wr_blk; cap_data = mem_wr_data;
    wr_cycle(1'b1, 32'h51, 32'h6, 1'b0);
    wr_cycle(1'b1, 32'h64, 32'h11, 1'b0);
    wr_cycle(1'b1, 32'h66, 32'h22, 1'b0);
    wr_cycle(1'b1, 32'h64, 32'h33, 1'b0);
    wr_cycle(1'b1, 32'h52, 32'h7, 1'b0);
    chk("R5", "head mask frozen", mem_wr_mask, 4'h1);
    chk("R5", "head block frozen", mem_wr_blk, cap_blk);
    chk("R5", "head data frozen", mem_wr_data, cap_data);
    wr_cycle(1'b0, 32'h0, 32'h0, 1'b1);
    chk("R5", "same block separate slot", mem_wr_blk, 30'h14);
    chk("R3", "merged mask", mem_wr_mask, 4'h6);
    chk("R3", "merged lane1", mem_wr_data[63:32], 32'h6);
    chk("R3", "merged lane2", mem_wr_data[95:64], 32'h7);
    chk("R2", "lane0 zero", mem_wr_data[31:0], 32'h0);
    wr_cycle(1'b0, 32'h0, 32'h0, 1'b1);
    chk("R6", "third block", mem_wr_blk, 30'h19);
    chk("R4", "overwrite mask", mem_wr_mask, 4'h5);
    chk("R4", "overwritten lane0", mem_wr_data[31:0], 32'h33);
    chk("R4", "lane2 kept", mem_wr_data[95:64], 32'h22);
    chk("R2", "lane1 zero", mem_wr_data[63:32], 32'h0);
    wr_cycle(1'b0, 32'h0, 32'h0, 1'b1);
    chk("R8", "empty after drain", mem_wr_valid, 1'b0);
    chk("R7", "no stall when empty", cpu_stall, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule